// File: doc/BRIEF.md
# Power Rail Turn-On / Turn-Off Sequencer

This block shapes the startup and shutdown of one converter output. A single enable input (the combination of a hardwired control line and a bus on/off command, merged outside this block) starts a turn-on. The block first holds its reference output at zero for a programmed wait. It then raises the reference linearly from zero to the target setpoint over a programmed number of clock ticks. Dropping the enable starts the mirror image: a programmed hold at the present level, then a linear descent to zero over its own programmed time.

All four timing values are in clock ticks. Because each instance has its own values, several rails can be started and stopped in a fixed order by giving them staggered waits and ramps. A fractional accumulator spreads the ramp over the exact tick count, so the final value is met on the last tick with no rounding residue. A power-good flag marks the settled on state.

Top module: `pwr_seq_ramp`

## Requirements
- R1: After reset, seq_state_o is 0 (off), vref_o is 0 and pwr_good_o is 0. The state codes are: 0 off, 1 turn-on wait, 2 rising, 3 on, 4 turn-off wait, 5 falling.
- R2: A high en_i sampled in the off state starts a turn-on wait lasting on_dly_i ticks, during which vref_o is 0. If on_dly_i is 0, the wait is skipped.
- R3: The rising state lasts rise_time_i ticks. In its k-th tick (k counted from 0), vref_o equals floor(target_i*k/rise_time_i). The next tick enters the on state with vref_o exactly equal to target_i.
- R4: A rise_time_i of 0 steps vref_o straight to target_i and enters the on state on the edge that ends the wait.
- R5: A low en_i sampled in the on state starts a turn-off wait lasting off_dly_i ticks, with vref_o held at its present value. If off_dly_i is 0, the wait is skipped.
- R6: The falling state starts from level S and lasts fall_time_i ticks. In its k-th tick, vref_o equals S - floor(S*k/fall_time_i). It then enters the off state with vref_o at 0. A fall_time_i of 0 goes to off with vref_o at 0 at once.
- R7: A low en_i sampled during the turn-on wait returns the block to off on that edge, with vref_o at 0.
- R8: A low en_i sampled during rising stops the ramp. The block enters the turn-off wait, or falling if off_dly_i is 0, holding the level reached, and the descent starts from that level.
- R9: Once a turn-off wait has begun, en_i is ignored until the off state is reached.
- R10: pwr_good_o is 1 exactly while seq_state_o is 3 (on).
- R11: Each timing value and the target are taken on the edge where their phase begins. Later changes have no effect on the running phase or on vref_o in the on state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Combined turn-on request |
| on_dly_i | input | TIME_W | Turn-on wait in ticks |
| rise_time_i | input | TIME_W | Rise duration in ticks |
| off_dly_i | input | TIME_W | Turn-off wait in ticks |
| fall_time_i | input | TIME_W | Fall duration in ticks |
| target_i | input | VAL_W | Final reference setpoint |
| vref_o | output | VAL_W | Ramped reference |
| seq_state_o | output | 3 | Current phase code |
| pwr_good_o | output | 1 | Settled-on flag |

## Verification
A corrupted phase counter appears at the ports as a phase that is one tick long or short. That shows in seq_state_o on the tick where the transition was expected. A faulty accumulator remainder drifts vref_o away from the floor-division value within a few ramp ticks, or leaves a residue on the step into the on state. A wrong abort or ignore decision shows in the state code on the edge right after en_i changes. So every check compares state, level and flag on every tick against values computed from the formulas above.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_OFF      = 3'd0,
    SEQ_ON_WAIT  = 3'd1,
    SEQ_RISE     = 3'd2,
    SEQ_ON       = 3'd3,
    SEQ_OFF_WAIT = 3'd4,
    SEQ_FALL     = 3'd5
  } seq_state_e;

  typedef enum logic [2:0] {
    RAMP_HOLD,
    RAMP_ZERO,
    RAMP_JUMP,
    RAMP_START_UP,
    RAMP_START_DN,
    RAMP_STEP,
    RAMP_FINISH_UP
  } ramp_op_e;

  typedef struct packed {
    seq_state_e st;
    ramp_op_e   op;
    logic       load;
  } seq_move_t;

endpackage

// File: rtl/seq_phase_timer.sv
`timescale 1ns/1ps
module seq_phase_timer #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [TIME_W-1:0] len_i,
  output logic              last_o
);

  logic [TIME_W-1:0] cnt_q, cnt_d;
  logic [TIME_W-1:0] len_q, len_d;
  logic [TIME_W:0]   cnt_plus;
  logic              cnt_en;

  // tick count of the current phase; last_o marks its final tick
  always_comb begin
    cnt_plus = {1'b0, cnt_q} + {{TIME_W{1'b0}}, 1'b1};
    last_o   = (cnt_plus == {1'b0, len_q});
    cnt_en   = load_i || (cnt_plus < {1'b0, len_q});
    cnt_d    = load_i ? '0 : cnt_plus[TIME_W-1:0];
    len_d    = load_i ? len_i : len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (load_i) len_q <= len_d;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) |-> (cnt_q < len_q));

endmodule

// File: rtl/seq_ramp_gen.sv
`timescale 1ns/1ps
module seq_ramp_gen
  import pwr_seq_pkg::*;
#(
  parameter int VAL_W  = 16,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ramp_op_e          op_i,
  input  logic [VAL_W-1:0]  target_i,
  input  logic [TIME_W-1:0] len_i,
  output logic [VAL_W-1:0]  vref_o
);

  localparam int DW = (VAL_W > TIME_W) ? VAL_W : TIME_W;

  logic [VAL_W-1:0]  vref_q, vref_d;
  logic [VAL_W-1:0]  base_q, base_d;
  logic [VAL_W-1:0]  goal_q, goal_d;
  logic [VAL_W-1:0]  inc_q_q, inc_q_d;
  logic [TIME_W-1:0] inc_r_q, inc_r_d;
  logic [VAL_W-1:0]  acc_q_q, acc_q_d;
  logic [TIME_W-1:0] acc_r_q, acc_r_d;
  logic [TIME_W-1:0] len_q, len_d;
  logic              dn_q, dn_d;
  logic              setup_en, step_en;

  logic [VAL_W-1:0]  delta;
  logic [DW-1:0]     dvd_ext, dvs_ext, quo_ext, rem_ext;
  logic [TIME_W:0]   sum_r;
  logic              wrap;
  logic [TIME_W:0]   nxt_r_ext;
  logic [VAL_W-1:0]  nxt_q;

  // per-tick increment split into whole and fractional part
  always_comb begin
    delta   = (op_i == RAMP_START_DN) ? vref_q : target_i;
    dvd_ext = DW'(delta);
    dvs_ext = (len_i == '0) ? DW'(1) : DW'(len_i);
    quo_ext = dvd_ext / dvs_ext;
    rem_ext = dvd_ext % dvs_ext;
  end

  // fractional accumulator step
  always_comb begin
    sum_r     = {1'b0, acc_r_q} + {1'b0, inc_r_q};
    wrap      = (sum_r >= {1'b0, len_q});
    nxt_r_ext = wrap ? (sum_r - {1'b0, len_q}) : sum_r;
    nxt_q     = acc_q_q + inc_q_q + {{(VAL_W-1){1'b0}}, wrap};
  end

  always_comb begin
    vref_d   = vref_q;
    base_d   = base_q;
    goal_d   = goal_q;
    inc_q_d  = inc_q_q;
    inc_r_d  = inc_r_q;
    acc_q_d  = acc_q_q;
    acc_r_d  = acc_r_q;
    len_d    = len_q;
    dn_d     = dn_q;
    setup_en = 1'b0;
    step_en  = 1'b0;
    unique case (op_i)
      RAMP_ZERO: vref_d = '0;
      RAMP_JUMP: begin
        vref_d   = target_i;
        goal_d   = target_i;
        setup_en = 1'b1;
      end
      RAMP_START_UP, RAMP_START_DN: begin
        setup_en = 1'b1;
        dn_d     = (op_i == RAMP_START_DN);
        base_d   = (op_i == RAMP_START_DN) ? vref_q : '0;
        vref_d   = (op_i == RAMP_START_DN) ? vref_q : '0;
        if (op_i == RAMP_START_UP) goal_d = target_i;
        inc_q_d  = quo_ext[VAL_W-1:0];
        inc_r_d  = rem_ext[TIME_W-1:0];
        acc_q_d  = '0;
        acc_r_d  = '0;
        len_d    = len_i;
      end
      RAMP_STEP: begin
        step_en = 1'b1;
        acc_q_d = nxt_q;
        acc_r_d = nxt_r_ext[TIME_W-1:0];
        vref_d  = dn_q ? (base_q - nxt_q) : (base_q + nxt_q);
      end
      RAMP_FINISH_UP: vref_d = goal_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vref_q  <= '0;
      base_q  <= '0;
      goal_q  <= '0;
      inc_q_q <= '0;
      inc_r_q <= '0;
      acc_q_q <= '0;
      acc_r_q <= '0;
      len_q   <= '0;
      dn_q    <= 1'b0;
    end else begin
      vref_q <= vref_d;
      if (setup_en) begin
        base_q  <= base_d;
        goal_q  <= goal_d;
        inc_q_q <= inc_q_d;
        inc_r_q <= inc_r_d;
        len_q   <= len_d;
        dn_q    <= dn_d;
      end
      if (setup_en || step_en) begin
        acc_q_q <= acc_q_d;
        acc_r_q <= acc_r_d;
      end
    end
  end

  assign vref_o = vref_q;

  // R3
  rise_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == RAMP_STEP && !dn_q) |=> (vref_o >= $past(vref_o)));

  // R3
  rise_below_goal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == RAMP_STEP && !dn_q) |=> (vref_o <= goal_q));

  // R6
  fall_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == RAMP_STEP && dn_q) |=> (vref_o <= $past(vref_o)));

endmodule

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [TIME_W-1:0] on_dly_i,
  input  logic [TIME_W-1:0] rise_i,
  input  logic [TIME_W-1:0] off_dly_i,
  input  logic [TIME_W-1:0] fall_i,
  input  logic              last_i,
  output seq_state_e        state_o,
  output ramp_op_e          ramp_op_o,
  output logic              tmr_load_o,
  output logic [TIME_W-1:0] tmr_len_o,
  output logic              pwr_good_o
);

  seq_state_e st_q, st_d;
  logic       pg_q;

  seq_move_t  mv_rise, mv_fall, mv_offw, mv_onw, mv;
  logic [TIME_W-1:0] len_rise, len_fall, len_offw, len_onw, len_sel;

  // phase-entry decisions, zero lengths skip their phase
  always_comb begin
    if (rise_i != '0) begin
      mv_rise  = '{st: SEQ_RISE, op: RAMP_START_UP, load: 1'b1};
      len_rise = rise_i;
    end else begin
      mv_rise  = '{st: SEQ_ON, op: RAMP_JUMP, load: 1'b0};
      len_rise = '0;
    end

    if (fall_i != '0) begin
      mv_fall  = '{st: SEQ_FALL, op: RAMP_START_DN, load: 1'b1};
      len_fall = fall_i;
    end else begin
      mv_fall  = '{st: SEQ_OFF, op: RAMP_ZERO, load: 1'b0};
      len_fall = '0;
    end

    if (off_dly_i != '0) begin
      mv_offw  = '{st: SEQ_OFF_WAIT, op: RAMP_HOLD, load: 1'b1};
      len_offw = off_dly_i;
    end else begin
      mv_offw  = mv_fall;
      len_offw = len_fall;
    end

    if (on_dly_i != '0) begin
      mv_onw  = '{st: SEQ_ON_WAIT, op: RAMP_ZERO, load: 1'b1};
      len_onw = on_dly_i;
    end else begin
      mv_onw  = mv_rise;
      len_onw = len_rise;
    end
  end

  // next-state selection
  always_comb begin
    mv      = '{st: st_q, op: RAMP_HOLD, load: 1'b0};
    len_sel = '0;
    unique case (st_q)
      SEQ_OFF: begin
        if (en_i) begin
          mv = mv_onw;  len_sel = len_onw;
        end
      end
      SEQ_ON_WAIT: begin
        if (!en_i) begin
          mv = '{st: SEQ_OFF, op: RAMP_ZERO, load: 1'b0};
        end else if (last_i) begin
          mv = mv_rise; len_sel = len_rise;
        end
      end
      SEQ_RISE: begin
        if (!en_i) begin
          mv = mv_offw; len_sel = len_offw;
        end else if (last_i) begin
          mv = '{st: SEQ_ON, op: RAMP_FINISH_UP, load: 1'b0};
        end else begin
          mv.op = RAMP_STEP;
        end
      end
      SEQ_ON: begin
        if (!en_i) begin
          mv = mv_offw; len_sel = len_offw;
        end
      end
      SEQ_OFF_WAIT: begin
        if (last_i) begin
          mv = mv_fall; len_sel = len_fall;
        end
      end
      SEQ_FALL: begin
        if (last_i) begin
          mv = '{st: SEQ_OFF, op: RAMP_ZERO, load: 1'b0};
        end else begin
          mv.op = RAMP_STEP;
        end
      end
      default: mv = '{st: SEQ_OFF, op: RAMP_ZERO, load: 1'b0};
    endcase
    st_d       = mv.st;
    ramp_op_o  = mv.op;
    tmr_load_o = mv.load;
    tmr_len_o  = len_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEQ_OFF;
      pg_q <= 1'b0;
    end else begin
      st_q <= st_d;
      pg_q <= (st_d == SEQ_ON);
    end
  end

  assign state_o    = st_q;
  assign pwr_good_o = pg_q;

  // R7
  abort_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_ON_WAIT && !en_i) |=> (st_q == SEQ_OFF));

  // R8
  rise_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_RISE && !en_i) |=> (st_q inside {SEQ_OFF_WAIT, SEQ_FALL, SEQ_OFF}));

  // R9
  off_wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_OFF_WAIT) |=> (st_q inside {SEQ_OFF_WAIT, SEQ_FALL, SEQ_OFF}));

  // R9
  fall_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_FALL) |=> (st_q inside {SEQ_FALL, SEQ_OFF}));

endmodule

// File: rtl/pwr_seq_ramp.sv
`timescale 1ns/1ps
module pwr_seq_ramp
  import pwr_seq_pkg::*;
#(
  parameter int VAL_W  = 16,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [TIME_W-1:0] on_dly_i,
  input  logic [TIME_W-1:0] rise_time_i,
  input  logic [TIME_W-1:0] off_dly_i,
  input  logic [TIME_W-1:0] fall_time_i,
  input  logic [VAL_W-1:0]  target_i,
  output logic [VAL_W-1:0]  vref_o,
  output logic [2:0]        seq_state_o,
  output logic              pwr_good_o
);

  logic              rst_meta, rst_n_int;
  seq_state_e        state;
  ramp_op_e          ramp_op;
  logic              tmr_load, tmr_last;
  logic [TIME_W-1:0] tmr_len;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  seq_ctrl #(.TIME_W(TIME_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .en_i       (en_i),
    .on_dly_i   (on_dly_i),
    .rise_i     (rise_time_i),
    .off_dly_i  (off_dly_i),
    .fall_i     (fall_time_i),
    .last_i     (tmr_last),
    .state_o    (state),
    .ramp_op_o  (ramp_op),
    .tmr_load_o (tmr_load),
    .tmr_len_o  (tmr_len),
    .pwr_good_o (pwr_good_o)
  );

  seq_phase_timer #(.TIME_W(TIME_W)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .last_o (tmr_last)
  );

  seq_ramp_gen #(.VAL_W(VAL_W), .TIME_W(TIME_W)) ramp_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .op_i     (ramp_op),
    .target_i (target_i),
    .len_i    (tmr_len),
    .vref_o   (vref_o)
  );

  assign seq_state_o = state;

  // R2
  wait_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (state == SEQ_ON_WAIT) |-> (vref_o == '0));

  // R8
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (state == SEQ_RISE && !en_i && off_dly_i != '0) |=> (vref_o == $past(vref_o)));

  // R10
  pg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(pwr_good_o) |-> (state == SEQ_ON && $past(state) != SEQ_ON));

  // R10
  pg_fall_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(pwr_good_o) |-> (state != SEQ_ON));

endmodule

// File: tb/pwr_seq_ramp_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_ramp_tb_top;

  localparam logic [2:0] S_OFF = 3'd0, S_ONW = 3'd1, S_RISE = 3'd2,
                         S_ON = 3'd3, S_OFFW = 3'd4, S_FALL = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [15:0] on_dly, rise_t, off_dly, fall_t, target;
  logic [15:0] vref;
  logic [2:0]  seq_state;
  logic        pg;

  typedef struct {
    logic [2:0] st;
    int         v;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #10 clk = ~clk;

  pwr_seq_ramp dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en),
    .on_dly_i    (on_dly),
    .rise_time_i (rise_t),
    .off_dly_i   (off_dly),
    .fall_time_i (fall_t),
    .target_i    (target),
    .vref_o      (vref),
    .seq_state_o (seq_state),
    .pwr_good_o  (pg)
  );

  // driver: one tick per call, expectation for the coming edge
  task automatic cyc(input logic e, input logic [2:0] st, input int v, input string tag);
    en = e;
    exp_q.push_back('{st: st, v: v, tag: tag});
    @(negedge clk);
  endtask

  task automatic set_times(input int a, input int b, input int c, input int d, input int t);
    on_dly  = 16'(a);
    rise_t  = 16'(b);
    off_dly = 16'(c);
    fall_t  = 16'(d);
    target  = 16'(t);
  endtask

  task automatic rise_run(input int len, input int tgt, input string tag);
    for (int k = 0; k < len; k++) cyc(1'b1, S_RISE, (tgt * k) / len, tag);
  endtask

  task automatic fall_run(input int len, input int s, input string tag);
    for (int k = 0; k < len; k++) cyc(1'b0, S_FALL, s - (s * k) / len, tag);
  endtask

  // monitor: compare a quarter period after each active edge
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        checks++;
        if (seq_state !== it.st || int'(vref) !== it.v || pg !== (it.st == S_ON)) begin
          errors++;
          $display("FAIL %s: state=%0d vref=%0d pg=%0b expected state=%0d vref=%0d pg=%0b",
                   it.tag, seq_state, vref, pg, it.st, it.v, (it.st == S_ON));
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    set_times(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (seq_state !== S_OFF || vref !== 16'd0 || pg !== 1'b0) begin
      errors++;
      $display("FAIL R1: state=%0d vref=%0d pg=%0b expected state=0 vref=0 pg=0", seq_state, vref, pg);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cyc(1'b0, S_OFF, 0, "R1");

    // R2 R3 R10: wait 3, rise 4 to 1000
    set_times(3, 4, 2, 4, 1000);
    for (int i = 0; i < 3; i++) cyc(1'b1, S_ONW, 0, "R2");
    rise_run(4, 1000, "R3");
    cyc(1'b1, S_ON, 1000, "R3");
    cyc(1'b1, S_ON, 1000, "R10");

    // R5 R6: off wait 2, fall 4
    cyc(1'b0, S_OFFW, 1000, "R5");
    cyc(1'b0, S_OFFW, 1000, "R5");
    fall_run(4, 1000, "R6");
    cyc(1'b0, S_OFF, 0, "R6");

    // R4 and zero-length turn-off (R6)
    set_times(0, 0, 0, 0, 777);
    cyc(1'b1, S_ON, 777, "R4");
    cyc(1'b1, S_ON, 777, "R4");
    cyc(1'b0, S_OFF, 0, "R6");

    // R7 abort during turn-on wait
    set_times(5, 2, 0, 0, 500);
    cyc(1'b1, S_ONW, 0, "R7");
    cyc(1'b1, S_ONW, 0, "R7");
    cyc(1'b0, S_OFF, 0, "R7");
    cyc(1'b0, S_OFF, 0, "R7");

    // R8 drop during rising
    set_times(0, 8, 1, 2, 800);
    cyc(1'b1, S_RISE, 0, "R8");
    cyc(1'b1, S_RISE, 100, "R8");
    cyc(1'b1, S_RISE, 200, "R8");
    cyc(1'b0, S_OFFW, 200, "R8");
    cyc(1'b0, S_FALL, 200, "R8");
    cyc(1'b0, S_FALL, 100, "R8");
    cyc(1'b0, S_OFF, 0, "R8");

    // R9 enable ignored during shutdown
    set_times(0, 0, 3, 2, 300);
    cyc(1'b1, S_ON, 300, "R9");
    cyc(1'b0, S_OFFW, 300, "R9");
    cyc(1'b1, S_OFFW, 300, "R9");
    cyc(1'b1, S_OFFW, 300, "R9");
    cyc(1'b1, S_FALL, 300, "R9");
    cyc(1'b1, S_FALL, 150, "R9");
    cyc(1'b0, S_OFF, 0, "R9");

    // R11 inputs changed mid-ramp and in the on state
    set_times(2, 4, 0, 0, 400);
    cyc(1'b1, S_ONW, 0, "R11");
    cyc(1'b1, S_ONW, 0, "R11");
    cyc(1'b1, S_RISE, 0, "R11");
    set_times(0, 1, 0, 0, 999);
    cyc(1'b1, S_RISE, 100, "R11");
    cyc(1'b1, S_RISE, 200, "R11");
    cyc(1'b1, S_RISE, 300, "R11");
    cyc(1'b1, S_ON, 400, "R11");
    cyc(1'b1, S_ON, 400, "R11");
    cyc(1'b0, S_OFF, 0, "R11");

    // R3 uneven division and full scale, R6 uneven fall
    set_times(0, 3, 0, 0, 1000);
    rise_run(3, 1000, "R3");
    cyc(1'b1, S_ON, 1000, "R3");
    cyc(1'b0, S_OFF, 0, "R6");
    set_times(0, 2, 0, 3, 65535);
    rise_run(2, 65535, "R3");
    cyc(1'b1, S_ON, 65535, "R3");
    fall_run(3, 65535, "R6");
    cyc(1'b0, S_OFF, 0, "R6");
    cyc(1'b0, S_OFF, 0, "R1");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule